// File: doc/BRIEF.md
# Hash Permutation Step Unit

This block performs one step of a 256-bit hash permutation. The state arrives as eight 32-bit words. A start strobe loads the state and two 32-bit step constants. The block then applies three transforms in a fixed order:

- a nonlinear substitution on 4-bit crumbs, where each crumb takes one bit from each of four words;
- a linear XOR-and-rotate mix of word pairs;
- the injection of the two constants.

It returns the new state together with a one-cycle done pulse. A caller that drives a full permutation issues one start per step and feeds each result back as the next input.

The 4-bit substitution table is built one of two ways, selected by a parameter. It can be combinational logic, or a registered 16-entry memory that costs one extra cycle. The block is controlled by a small state machine with four named states:

- `ST_IDLE` waits for start. With start high it goes to `ST_CALC` for the logic table, or to `ST_FETCH` for the memory table.
- `ST_FETCH` lets the table memories read the loaded words, then always goes to `ST_CALC`.
- `ST_CALC` writes the result register, then always goes to `ST_DONE`.
- `ST_DONE` raises done, then always returns to `ST_IDLE`.

Top module: `perm_step`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o` is 0 and `state_o` is all zeros.
- R2: A start sampled in `ST_IDLE` captures `state_i` and both constants. Word k of the state is bits `32k+31 .. 32k` of `state_i` and of `state_o`, for k = 0..7.
- R3: Lower-group substitution. For each bit position j, the index is `{w3[j], w2[j], w1[j], w0[j]}`, with w0 as the least significant bit. The looked-up value is written back with its bit 0 to w0[j] and its bit 3 to w3[j].
- R4: Upper-group substitution. For each bit position j, the index is `{w4[j], w5[j], w6[j], w7[j]}`, with w7 as the least significant bit. The looked-up value is written back in the same reversed order.
- R5: The substitution table maps inputs 0..15 to D, E, 0, 1, 5, A, 7, 6, B, 3, 9, C, F, 8, 2, 4 (hex).
- R6: After substitution, each pair (x = w_k, y = w_{k+4}), k = 0..3, is mixed in this order:
  - y ^= x
  - x = rotl(x, 2) ^ y
  - y = rotl(y, 14) ^ x
  - x = rotl(x, 10)
  - y = rotl(y, 1)
  - x ^= y
- R7: After mixing, `const_lo_i` is XORed into w0 and `const_hi_i` is XORed into w4. The other words pass through unchanged.
- R8: `done_o` is high during the second cycle after the edge that accepts start with the logic table, and during the third cycle with the memory table.
- R9: `done_o` is high for exactly one cycle per accepted start. `state_o` changes only in the cycle where `done_o` rises, and holds otherwise.
- R10: A start in any state other than `ST_IDLE` is ignored: no extra done pulse, and no change to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| state_i | input | 256 | Input state, word k at bits 32k+31..32k |
| const_lo_i | input | 32 | Constant XORed into word 0 |
| const_hi_i | input | 32 | Constant XORed into word 4 |
| state_o | output | 256 | Stepped state, same word packing |
| done_o | output | 1 | One-cycle pulse when `state_o` is updated |

## Verification
The hardest situation to bring about is a start strobe that arrives while a step is in flight. This includes the `ST_DONE` cycle, where the logic-table variant is one edge away from accepting again. The bench runs both variants side by side from the same stimulus, so each sees the same stimulus at a different phase of its own sequence. On selected steps it holds start high with an inverted state for the two cycles after acceptance. That places the logic variant's strobes in `ST_CALC` and `ST_DONE`, and the memory variant's in `ST_FETCH` and `ST_CALC`. The bench then counts done pulses and compares the result against a model given only the first state. The table is swept exhaustively through uniform crumb patterns in both word orders, and a walking single bit covers every crumb position of every word.

// File: rtl/perm_step_pkg.sv
package perm_step_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CALC  = 2'd2,
        ST_DONE  = 2'd3
    } step_state_e;

    // 4-bit nonlinear substitution table (R5)
    function automatic logic [3:0] crumb_sub(input logic [3:0] idx);
        logic [3:0] r;
        unique case (idx)
            4'h0: r = 4'hD;
            4'h1: r = 4'hE;
            4'h2: r = 4'h0;
            4'h3: r = 4'h1;
            4'h4: r = 4'h5;
            4'h5: r = 4'hA;
            4'h6: r = 4'h7;
            4'h7: r = 4'h6;
            4'h8: r = 4'hB;
            4'h9: r = 4'h3;
            4'hA: r = 4'h9;
            4'hB: r = 4'hC;
            4'hC: r = 4'hF;
            4'hD: r = 4'h8;
            4'hE: r = 4'h2;
            default: r = 4'h4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/perm_sbox.sv
module perm_sbox
    import perm_step_pkg::*;
#(
    parameter bit USE_MEM = 1'b0
) (
    input  logic       clk,
    input  logic       en,
    input  logic [3:0] idx,
    output logic [3:0] val
);
    localparam int DEPTH = 16;

    generate
        if (USE_MEM) begin : g_mem
            logic [3:0] rom [DEPTH];
            logic [3:0] rd_q;

            always_comb begin
                for (int i = 0; i < DEPTH; i++) begin
                    rom[i] = crumb_sub(4'(i));
                end
            end

            always_ff @(posedge clk) begin
                if (en) begin
                    rd_q <= rom[idx];
                end
            end

            assign val = rd_q;
        end else begin : g_logic
            logic unused_clk_en;
            assign unused_clk_en = clk ^ en;
            assign val = crumb_sub(idx);
        end
    endgenerate

endmodule

// File: rtl/perm_mixer.sv
module perm_mixer #(
    parameter int W     = 32,
    parameter int ROT_A = 2,
    parameter int ROT_B = 14,
    parameter int ROT_C = 10,
    parameter int ROT_D = 1
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);
    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int r);
        return (v << r) | (v >> (W - r));
    endfunction

    logic [W-1:0] y1, x1, y2, x2, y3;

    always_comb begin
        y1  = y_i ^ x_i;
        x1  = rotl(x_i, ROT_A) ^ y1;
        y2  = rotl(y1, ROT_B) ^ x1;
        x2  = rotl(x1, ROT_C);
        y3  = rotl(y2, ROT_D);
        x_o = x2 ^ y3;
        y_o = y3;
    end

endmodule

// File: rtl/perm_step.sv
module perm_step
    import perm_step_pkg::*;
#(
    parameter int W            = 32,
    parameter bit USE_MEM_SBOX = 1'b0,
    parameter int ROT_A        = 2,
    parameter int ROT_B        = 14,
    parameter int ROT_C        = 10,
    parameter int ROT_D        = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [8*W-1:0] state_i,
    input  logic [W-1:0]   const_lo_i,
    input  logic [W-1:0]   const_hi_i,
    output logic [8*W-1:0] state_o,
    output logic           done_o
);
    localparam int NW   = 8;
    localparam int HALF = NW / 2;
    localparam int SW   = NW * W;

    step_state_e st_q, st_d;
    logic        load_en, write_en, sbox_en;

    logic [W-1:0]  w_q  [NW];
    logic [W-1:0]  sw   [NW];
    logic [W-1:0]  mx   [NW];
    logic [W-1:0]  nw   [NW];
    logic [W-1:0]  c_lo_q, c_hi_q;
    logic [SW-1:0] nxt_flat, out_q;
    logic [3:0]    idx_lo [W];
    logic [3:0]    idx_hi [W];
    logic [3:0]    s_lo   [W];
    logic [3:0]    s_hi   [W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_i) st_d = USE_MEM_SBOX ? ST_FETCH : ST_CALC;
            ST_FETCH: st_d = ST_CALC;
            ST_CALC:  st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        load_en  = (st_q == ST_IDLE) && start_i;
        sbox_en  = (st_q == ST_FETCH);
        write_en = (st_q == ST_CALC);
        done_o   = (st_q == ST_DONE);
    end

    // crumb gathering: lower group forward, upper group reversed
    always_comb begin
        for (int j = 0; j < W; j++) begin
            idx_lo[j] = {w_q[3][j], w_q[2][j], w_q[1][j], w_q[0][j]};
            idx_hi[j] = {w_q[4][j], w_q[5][j], w_q[6][j], w_q[7][j]};
        end
    end

    generate
        for (genvar j = 0; j < W; j++) begin : g_crumb
            perm_sbox #(.USE_MEM(USE_MEM_SBOX)) u_sb_lo (
                .clk(clk), .en(sbox_en), .idx(idx_lo[j]), .val(s_lo[j])
            );
            perm_sbox #(.USE_MEM(USE_MEM_SBOX)) u_sb_hi (
                .clk(clk), .en(sbox_en), .idx(idx_hi[j]), .val(s_hi[j])
            );
        end
    endgenerate

    // scatter substituted crumbs back to the same bit positions
    always_comb begin
        for (int j = 0; j < W; j++) begin
            for (int b = 0; b < HALF; b++) begin
                sw[b][j]        = s_lo[j][b];
                sw[NW-1-b][j]   = s_hi[j][b];
            end
        end
    end

    generate
        for (genvar k = 0; k < HALF; k++) begin : g_mix
            perm_mixer #(
                .W(W), .ROT_A(ROT_A), .ROT_B(ROT_B), .ROT_C(ROT_C), .ROT_D(ROT_D)
            ) u_mix (
                .x_i(sw[k]), .y_i(sw[k+HALF]), .x_o(mx[k]), .y_o(mx[k+HALF])
            );
        end
    endgenerate

    // constant injection and packing
    always_comb begin
        for (int k = 0; k < NW; k++) begin
            nw[k] = mx[k];
        end
        nw[0]    = mx[0] ^ c_lo_q;
        nw[HALF] = mx[HALF] ^ c_hi_q;
        for (int k = 0; k < NW; k++) begin
            nxt_flat[k*W +: W] = nw[k];
        end
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NW; k++) begin
                w_q[k] <= '0;
            end
            c_lo_q <= '0;
            c_hi_q <= '0;
            out_q  <= '0;
        end else begin
            if (load_en) begin
                for (int k = 0; k < NW; k++) begin
                    w_q[k] <= state_i[k*W +: W];
                end
                c_lo_q <= const_lo_i;
                c_hi_q <= const_hi_i;
            end
            if (write_en) begin
                out_q <= nxt_flat;
            end
        end
    end

    assign state_o = out_q;

endmodule

// File: rtl/perm_step_checker.sv
module perm_step_checker
    import perm_step_pkg::*;
#(
    parameter bit USE_MEM = 1'b0,
    parameter int SW      = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic [SW-1:0] state_o,
    input step_state_e   st
);
    localparam int LAT = USE_MEM ? 3 : 2;

    // R8: done follows an accepted start after the variant's latency
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start_i) |-> ##LAT done_o);

    // R9: done is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: the result moves only together with done
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_o) |-> done_o);

    // R10: a strobe in the done cycle does not restart the step
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DONE && start_i) |=> (st == ST_IDLE));

    // R1: no done in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !done_o);

endmodule

bind perm_step perm_step_checker #(.USE_MEM(USE_MEM_SBOX), .SW(8*W)) u_perm_step_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .state_o(state_o), .st(st_q)
);

// File: tb/perm_step_bench.sv
`timescale 1ns/1ps
module perm_step_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [255:0] state_i = '0;
    logic [31:0]  const_lo_i = '0, const_hi_i = '0;
    logic [255:0] out_l, out_m;
    logic         done_l, done_m;
    int           n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    perm_step #(.USE_MEM_SBOX(1'b0)) u_perm_step (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_i(state_i),
        .const_lo_i(const_lo_i), .const_hi_i(const_hi_i),
        .state_o(out_l), .done_o(done_l)
    );
    perm_step #(.USE_MEM_SBOX(1'b1)) u_perm_step_mem (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .state_i(state_i),
        .const_lo_i(const_lo_i), .const_hi_i(const_hi_i),
        .state_o(out_m), .done_o(done_m)
    );

    function automatic logic [3:0] tsub(input int v);
        logic [3:0] t [16] = '{4'hD, 4'hE, 4'h0, 4'h1, 4'h5, 4'hA, 4'h7, 4'h6,
                               4'hB, 4'h3, 4'h9, 4'hC, 4'hF, 4'h8, 4'h2, 4'h4};
        return t[v];
    endfunction

    function automatic logic [31:0] rl(input logic [31:0] x, input int r);
        return (x << r) | (x >> (32 - r));
    endfunction

    function automatic logic [255:0] model(input logic [255:0] s,
                                           input logic [31:0] c0, input logic [31:0] c4);
        logic [31:0]  a [8];
        logic [31:0]  x, y;
        logic [255:0] r;
        int           lo, hi;
        logic [3:0]   sl, sh;
        for (int k = 0; k < 8; k++) a[k] = s[32*k +: 32];
        for (int j = 0; j < 32; j++) begin
            lo = a[0][j] + 2*a[1][j] + 4*a[2][j] + 8*a[3][j];
            hi = a[7][j] + 2*a[6][j] + 4*a[5][j] + 8*a[4][j];
            sl = tsub(lo);
            sh = tsub(hi);
            a[0][j] = sl[0]; a[1][j] = sl[1]; a[2][j] = sl[2]; a[3][j] = sl[3];
            a[7][j] = sh[0]; a[6][j] = sh[1]; a[5][j] = sh[2]; a[4][j] = sh[3];
        end
        for (int k = 0; k < 4; k++) begin
            x = a[k]; y = a[k+4];
            y = y ^ x;
            x = rl(x, 2) ^ y;
            y = rl(y, 14) ^ x;
            x = rl(x, 10);
            y = rl(y, 1);
            x = x ^ y;
            a[k] = x; a[k+4] = y;
        end
        a[0] = a[0] ^ c0;
        a[4] = a[4] ^ c4;
        for (int k = 0; k < 8; k++) r[32*k +: 32] = a[k];
        return r;
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic run_step(input logic [255:0] s, input logic [31:0] c0,
                            input logic [31:0] c4, input bit poke, input string req);
        logic [255:0] exp = model(s, c0, c4);
        logic [255:0] got_l = 'x, got_m = 'x;
        int lat_l = 0, lat_m = 0, nd_l = 0, nd_m = 0;
        state_i = s; const_lo_i = c0; const_hi_i = c4; start_i = 1'b1;
        for (int n = 1; n <= 7; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (poke && n <= 2) begin
                start_i = 1'b1; state_i = ~s; const_lo_i = ~c0; const_hi_i = ~c4;
            end else begin
                start_i = 1'b0;
            end
            if (done_l) begin nd_l++; lat_l = n; got_l = out_l; end
            if (done_m) begin nd_m++; lat_m = n; got_m = out_m; end
        end
        check({req, " logic table"}, got_l, exp);
        check({req, " memory table"}, got_m, exp);
        check("R8 latency logic", 256'(lat_l), 256'd2);
        check("R8 latency memory", 256'(lat_m), 256'd3);
        check(poke ? "R10 pulses logic" : "R9 pulses logic", 256'(nd_l), 256'd1);
        check(poke ? "R10 pulses memory" : "R9 pulses memory", 256'(nd_m), 256'd1);
        check("R9 hold logic", out_l, exp);
        check("R9 hold memory", out_m, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [255:0] s;
        logic [63:0]  rs;
        repeat (3) @(negedge clk);
        // R1: held in reset
        check("R1 done in reset", 256'({done_l, done_m}), 256'd0);
        check("R1 state in reset", out_l | out_m, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", 256'({done_l, done_m}), 256'd0);
        check("R1 state after reset", out_l | out_m, '0);

        // R3 R4 R5: every table input on both crumb groups, no constants
        for (int v = 0; v < 16; v++) begin
            s = '0;
            for (int b = 0; b < 4; b++) begin
                s[32*b +: 32]     = {32{v[b]}};
                s[32*(7-b) +: 32] = {32{v[b]}};
            end
            run_step(s, 32'h0, 32'h0, 1'b0, "R3 R4 R5 R6 uniform crumbs");
        end
        // R3 R4 R6: every table input in the lower group, reversed value above
        for (int v = 0; v < 16; v++) begin
            s = '0;
            for (int b = 0; b < 4; b++) begin
                s[32*b +: 32]     = {16{v[b], ~v[b]}};
                s[32*(4+b) +: 32] = {32{v[b]}};
            end
            run_step(s, 32'h0, 32'h0, 1'b0, "R3 R4 R6 split crumbs");
        end
        // R2 R3 R4: walking single bit across every word and crumb position
        for (int p = 0; p < 256; p++) begin
            s = '0;
            s[p] = 1'b1;
            run_step(s, 32'(p * 32'h0101_0101), 32'(~p), p[0], "R2 R3 R4 walking bit");
        end
        // R7: constants alone on a zero state
        run_step('0, 32'hFFFF_FFFF, 32'h0, 1'b0, "R7 low constant");
        run_step('0, 32'h0, 32'h8000_0001, 1'b0, "R7 high constant");
        // R2 R6 R7 R10: pseudo-random states, with strobes while busy
        rs = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 40; i++) begin
            for (int k = 0; k < 4; k++) begin
                rs = rs ^ (rs << 13); rs = rs ^ (rs >> 7); rs = rs ^ (rs << 17);
                s[64*k +: 64] = rs;
            end
            run_step(s, rs[31:0], rs[63:32], i[0], "R2 R6 R7 R10 mixed");
        end
        summary();
        $finish;
    end

endmodule